// File: doc/BRIEF.md
# Asynchronous-Handshake Bus Master Cycle Sequencer

This block is the master side of a strobe-and-acknowledge memory bus, of the kind used by 68000-family peripherals. A client hands it one request at a time: address, write data, direction and a count of wait states. The block then runs a single read or write cycle. It drives the address strobe, the data strobe, the read/write line, the address and the write data with its output enable. It waits for the slave to end the cycle on one of two acknowledge inputs. When the cycle is over it gives one done pulse, and for a read it returns the sampled data.

A cycle starts with one T1 state and continues with one or more T2 states. T2 repeats until an acknowledge is honoured. The first acknowledge input is asynchronous: it passes through a two-stage synchronizer, and the synchronized value is honoured from T1 onward. The second acknowledge input is synchronous: it is sampled directly on the clock, and it is honoured from the first T2 onward. The programmed wait count holds off both acknowledges for that many additional T2 states. The data strobe is only used when that count is non-zero. When a read follows a write, the block inserts one idle turnaround state. During that state the write driver is still on, and it is released at the clock edge that ends the idle state.

Every output changes on the rising edge of the single bus clock. Reset is synchronous and active high.

Top module: `hs_bus_master`

## Requirements
- R1: After reset, as_n, ds_n and rw_n are 1, dout_oe and done are 0, and req_ready is 1.
- R2: req_ready is 1 only while the sequencer is idle. It is 0 in every clock in which as_n is low and during the turnaround state. A request is accepted on a rising edge where req_valid and req_ready are both 1.
- R3: The asynchronous acknowledge ack_async_n is active low and passes through two flops before use. If it has been held low for at least three clocks before a request with req_wait = 0, as_n is low for exactly one clock (T1 only).
- R4: The synchronous acknowledge ack_sync_n is active low and is sampled directly. It is never honoured in T1. If it is held low with req_wait = 0, as_n is low for exactly two clocks.
- R5: With req_wait = N > 0 and either acknowledge held active, as_n is low for exactly N+2 clocks.
- R6: Without an acknowledge, T2 repeats: as_n stays low and done stays 0. An acknowledge on ack_sync_n then ends the cycle at the next rising edge.
- R7: ds_n goes low only in cycles with req_wait > 0. It is low from the second clock of the cycle to its last clock, and it is never low while as_n is high.
- R8: rw_n is 0 for writes and 1 for reads, and it is stable while as_n is low. After a write it stays 0 while idle, so back-to-back writes never return it to 1.
- R9: A read accepted after a write spends exactly one clock in a turnaround state, with as_n high, dout_oe 1 and rw_n 0, before as_n falls. dout_oe is 0 from that falling edge on. Other sequences (read after read, or any write) start as_n in the clock right after acceptance.
- R10: done is a one-clock pulse. It is asserted in the clock after the last clock of as_n low, together with as_n high. For a read, rdata holds the value of din sampled on the terminating edge.
- R11: During a write cycle, dout_oe is 1 and dout equals the accepted req_wdata. During a read cycle, dout_oe is 0 while as_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_wait | input | WW | Extra T2 states before an acknowledge counts |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Read data captured at completion |
| bus_addr | output | AW | Bus address |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | Read/write line, 1 = read |
| dout | output | DW | Write data to the bus |
| dout_oe | output | 1 | Write data driver enable |
| din | input | DW | Read data from the bus |
| ack_async_n | input | 1 | Asynchronous termination acknowledge, active low |
| ack_sync_n | input | 1 | Synchronous termination acknowledge, active low |

## Verification
A wrong state or a wrong wait count appears at once in the number of clocks that as_n is low. Within the same transaction it also shows in the ds_n low count and in the clock in which done rises. A lost write flag shows in the clock after acceptance: as_n either falls one clock early or holds off when it should not, and dout_oe is released at the wrong edge. A fault in the synchronizer or in the acknowledge selection changes the held-acknowledge cycle lengths of one and two clocks by at least one clock. This is seen on the first transaction that uses that source.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_T1   = 2'd2,
    ST_T2   = 2'd3
  } hsb_state_t;
endpackage

// File: rtl/hsb_ack_sync.sv
module hsb_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_in,
  output logic ack_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], ~ack_n_in};
  end

  assign ack_out = chain[STAGES-1];
endmodule

// File: rtl/hsb_wait_cnt.sv
module hsb_wait_cnt #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [WW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: the sequencer never counts below zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
endmodule

// File: rtl/hs_bus_master.sv
module hs_bus_master
  import hsb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int WW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [WW-1:0] req_wait,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          as_n,
  output logic          ds_n,
  output logic          rw_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [DW-1:0] din,
  input  logic          ack_async_n,
  input  logic          ack_sync_n
);
  hsb_state_t state;
  logic       a_ack;
  logic       s_ack;
  logic       wz;
  logic       accept;
  logic       cnt_dec;
  logic       last_wr;
  logic       has_wait;
  logic       finish;

  hsb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ack_n_in(ack_async_n), .ack_out(a_ack)
  );

  assign s_ack     = ~ack_sync_n;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign cnt_dec   = (state == ST_T2) && !wz;
  assign finish    = wz && (((state == ST_T1) && a_ack) ||
                            ((state == ST_T2) && (a_ack || s_ack)));

  hsb_wait_cnt #(.WW(WW)) u_wait (
    .clk(clk), .rst(rst), .load(accept), .load_val(req_wait),
    .dec(cnt_dec), .zero(wz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      as_n     <= 1'b1;
      ds_n     <= 1'b1;
      rw_n     <= 1'b1;
      dout_oe  <= 1'b0;
      dout     <= '0;
      bus_addr <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      last_wr  <= 1'b0;
      has_wait <= 1'b0;
    end else begin
      done <= 1'b0;
      if (finish) begin
        state <= ST_IDLE;
        as_n  <= 1'b1;
        ds_n  <= 1'b1;
        done  <= 1'b1;
        rdata <= din;
      end else begin
        unique case (state)
          ST_IDLE: if (accept) begin
            bus_addr <= req_addr;
            dout     <= req_wdata;
            last_wr  <= req_write;
            has_wait <= (req_wait != '0);
            if (!req_write && last_wr) begin
              state <= ST_TURN;
            end else begin
              state   <= ST_T1;
              as_n    <= 1'b0;
              rw_n    <= ~req_write;
              dout_oe <= req_write;
            end
          end
          ST_TURN: begin
            state   <= ST_T1;
            as_n    <= 1'b0;
            rw_n    <= 1'b1;
            dout_oe <= 1'b0;
          end
          ST_T1: begin
            state <= ST_T2;
            if (has_wait) ds_n <= 1'b0;
          end
          ST_T2: state <= ST_T2;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: no new request is offered while a cycle runs
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !as_n |-> !req_ready);
  // R7: data strobe only inside an address strobe
  p_ds_inside_as_r7: assert property (@(posedge clk) disable iff (rst)
    !ds_n |-> !as_n);
  // R8: direction holds for the whole cycle
  p_rw_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!as_n && $past(!as_n)) |-> $stable(rw_n));
  // R10: done is a single-clock pulse after the strobe is released
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_as_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (as_n && $past(!as_n)));
  // R11: a read cycle never drives data
  p_read_no_drive_r11: assert property (@(posedge clk) disable iff (rst)
    (!as_n && rw_n) |-> !dout_oe);
endmodule

// File: tb/hs_bus_master_test.sv
module hs_bus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [WW-1:0] req_wait;
  logic          done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic          as_n, ds_n, rw_n, dout_oe;
  logic [DW-1:0] dout;
  logic [DW-1:0] din;
  logic          ack_async_n, ack_sync_n;

  int checks = 0;
  int errors = 0;
  bit tb_last_wr = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_bus_master #(.AW(AW), .DW(DW), .WW(WW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .done(done), .rdata(rdata), .bus_addr(bus_addr),
    .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dout(dout), .dout_oe(dout_oe),
    .din(din), .ack_async_n(ack_async_n), .ack_sync_n(ack_sync_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: async ack held; 1: sync ack held; 2: sync ack arrives after 6 strobe clocks
  function automatic int exp_len(input int mode, input int wt);
    if (mode == 2) return 6;
    if (mode == 0 && wt == 0) return 1;
    return wt + 2;
  endfunction

  function automatic int exp_ds(input int len, input int wt);
    return (wt > 0) ? len - 1 : 0;
  endfunction

  task automatic run_cycle(input bit wr, input int wt, input int mode);
    logic [DW-1:0] wd;
    logic [DW-1:0] rd;
    int as_cnt, ds_cnt, idle_cnt, n;
    bit seen_as, got_done, exp_idle;
    wd = DW'($urandom);
    rd = DW'($urandom);
    exp_idle = !wr && tb_last_wr;
    @(negedge clk);
    din = rd;
    if (mode == 0) begin
      ack_async_n = 1'b0;
      repeat (3) @(negedge clk);
    end else if (mode == 1) begin
      ack_sync_n = 1'b0;
    end
    check(req_ready == 1'b1, "R2 ready in idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'($urandom);
    req_wdata = wd;
    req_wait  = WW'(wt);
    as_cnt = 0; ds_cnt = 0; idle_cnt = 0; seen_as = 1'b0; got_done = 1'b0;
    for (n = 0; n < 60; n++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin
        got_done = 1'b1;
        break;
      end
      if (!as_n) begin
        seen_as = 1'b1;
        as_cnt++;
        if (!ds_n) ds_cnt++;
        check(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
        check(rw_n == !wr, "R8 rw level", int'(rw_n), int'(!wr));
        if (wr) check(dout_oe && dout == wd, "R11 write drive", int'(dout), int'(wd));
        else    check(dout_oe == 1'b0, "R9/R11 read released", int'(dout_oe), 0);
        if (mode == 2 && as_cnt == 6) ack_sync_n = 1'b0;
      end else if (!seen_as) begin
        idle_cnt++;
        check(ds_n == 1'b1, "R7 ds idle", int'(ds_n), 1);
        check(dout_oe == 1'b1 && rw_n == 1'b0, "R9 turnaround drive",
              int'({dout_oe, rw_n}), 2);
        check(req_ready == 1'b0, "R2 turnaround", int'(req_ready), 0);
      end
    end
    check(got_done, "R10 done seen", int'(got_done), 1);
    check(as_cnt == exp_len(mode, wt),
          mode == 0 ? "R3/R5 async length" : (mode == 1 ? "R4/R5 sync length" : "R6 stall length"),
          as_cnt, exp_len(mode, wt));
    check(ds_cnt == exp_ds(exp_len(mode, wt), wt), "R7 ds length", ds_cnt,
          exp_ds(exp_len(mode, wt), wt));
    check(idle_cnt == int'(exp_idle), "R9 idle count", idle_cnt, int'(exp_idle));
    check(as_n == 1'b1, "R10 strobe released", int'(as_n), 1);
    if (!wr) check(rdata == rd, "R10 read data", int'(rdata), int'(rd));
    ack_async_n = 1'b1;
    ack_sync_n  = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R10 one-clock done", int'(done), 0);
    check(rw_n == !wr, "R8 level kept in idle", int'(rw_n), int'(!wr));
    repeat (2) @(negedge clk);
    tb_last_wr = wr;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_wait = '0; din = '0;
    ack_async_n = 1'b1; ack_sync_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(as_n && ds_n && rw_n, "R1 strobes high", int'({as_n, ds_n, rw_n}), 7);
    check(!dout_oe && !done, "R1 driver off", int'({dout_oe, done}), 0);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    // directed corners
    run_cycle(1'b0, 0, 0);  // R3 async zero-wait
    run_cycle(1'b0, 0, 1);  // R4 sync zero-wait
    run_cycle(1'b1, 3, 0);  // R5 async waits
    run_cycle(1'b1, 0, 1);  // R8 write-write
    run_cycle(1'b0, 2, 1);  // R9 turnaround
    run_cycle(1'b0, 0, 2);  // R6 stall, read after read
    run_cycle(1'b1, 4, 2);  // R6 stall with waits
    run_cycle(1'b0, 1, 0);  // R9 after write, async
    for (int i = 0; i < 60; i++) begin
      int md;
      int wt;
      md = int'($urandom_range(0, 2));
      wt = int'($urandom_range(0, (md == 2) ? 4 : 7));
      run_cycle(1'($urandom_range(0, 1)), wt, md);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule